// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder

This block sits between a 16-bit controller that shares one set of pins for address and data and the devices on that bus: a RAM, a program ROM split into four 64K-byte banks, and a small file of four internal registers. While the address strobe is high, the bus carries an address. The block captures that address on the clock edge and holds it until the next strobe. It turns the held address into three active-low chip enables, and only one of them is low for any captured address. The two ROM bank bits come straight from controller port pins and reach the ROM unchanged.

The register window covers the top eight bytes below the ROM. The RAM gives up those bytes. Inside the window, the two lowest address bits pick one of four registers: a configuration register, a counter capture register, a serial data register and a status register. The upper half of the window repeats the lower half. The controller reads these registers with an active-low read strobe and writes them with an active-low write strobe. During a read, the block drives the data bus only while the strobe is low and the window is selected. The rest of the time it leaves the bus to others, which is modelled here by an output-enable signal. The counter and status registers take their values from outside logic and cannot be written from the bus.

Top module: `mux_bus_decoder`

## Requirements
- R1: The address is taken from `adIn` at every rising clock edge where `ale` is high. While `ale` is low, changes on `adIn` leave the held address and the chip enables unchanged.
- R2: While reset is active, and after reset until the first address is captured, all three chip enables are high, `rdOe` is low and `cfgOut` is zero.
- R3: A held address from 0x0000 to 0x1FF7 drives `ramCeN` low and both other enables high.
- R4: A held address from 0x1FF8 to 0x1FFF drives `regCeN` low and both other enables high.
- R5: A held address from 0x2000 to 0xFFFF drives `romCeN` low and both other enables high.
- R6: `romBank` always equals `bankSel`, in the same cycle and with no decoding.
- R7: `rdOe` is high exactly when `rdN` is low and the held address is in the register window. While `rdOe` is high, `rdData` shows the register picked by address bits [1:0]: 0 configuration, 1 counter, 2 serial, 3 status. Offsets 0x1FFC to 0x1FFF select the same registers as 0x1FF8 to 0x1FFB.
- R8: At a clock edge where `wrN` is low, `ale` is low and the held address is in the window, `adIn[7:0]` is stored in the configuration register (index 0) or the serial register (index 2). A write while the held address is outside the window changes no register.
- R9: Writes to index 1 (counter) and index 3 (status) are ignored. The counter register loads `cntIn` at each edge where `cntCap` is high. The status register loads `statIn` at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| ale | input | 1 | Address strobe, high while the bus carries an address |
| adIn | input | 16 | Shared address/data bus as seen by the block |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| bankSel | input | 2 | ROM bank bits from controller port pins |
| cntCap | input | 1 | Load strobe for the counter capture register |
| cntIn | input | 8 | Count value to capture |
| statIn | input | 8 | Status flags from outside logic |
| ramCeN | output | 1 | RAM chip enable, active low |
| regCeN | output | 1 | Register file enable, active low |
| romCeN | output | 1 | ROM chip enable, active low |
| romBank | output | 2 | ROM upper address bits, passed through |
| rdData | output | 8 | Register read data |
| rdOe | output | 1 | Bus drive enable for read data |
| cfgOut | output | 8 | Current configuration register contents |

## Verification
The decode is driven with the addresses on both sides of each region edge (0x1FF7/0x1FF8, 0x1FFF/0x2000) and with the extremes 0x0000 and 0xFFFF. This shows whether each comparison is off by one and whether each edge belongs to the correct region. Each capture is followed by a cycle in which `ale` is low and the bus carries data from another region. A decoder that follows the live bus instead of the held address fails this cycle. Register traffic uses both halves of the window, writes to the read-only slots, and a write while the RAM is selected. These cases separate a correct index decode from one that ignores the alias, lets a read-only slot take a write, or ignores the window check.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int NUM_REGS  = 4;
  localparam int REG_IDX_W = $clog2(NUM_REGS);

  typedef enum logic [REG_IDX_W-1:0] {
    REG_CFG  = 2'd0,
    REG_CNT  = 2'd1,
    REG_SER  = 2'd2,
    REG_STAT = 2'd3
  } regIdx_e;

  typedef struct packed {
    logic    wrCfg;
    logic    wrSer;
    logic    rdEn;
    regIdx_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/mbd_ctrl.sv
module mbd_ctrl
  import mbd_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h1FF8,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ale,
  input  logic [ADDR_W-1:0] adIn,
  input  logic              rdN,
  input  logic              wrN,
  output logic              ramCeN,
  output logic              regCeN,
  output logic              romCeN,
  output ctlStrobe_t        strb
);
  logic [ADDR_W-1:0] addrQ;
  logic              addrValid;
  logic              inRam, inReg, inRom;
  regIdx_e           idx;

  // Address capture: sampled only on edges with the strobe high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      addrValid <= 1'b0;
    end else if (ale) begin
      addrQ     <= adIn;
      addrValid <= 1'b1;
    end
  end

  // Region decode works from the held address only
  always_comb begin
    inRam = addrValid && (addrQ < REG_BASE);
    inReg = addrValid && (addrQ >= REG_BASE) && (addrQ < ROM_BASE);
    inRom = addrValid && (addrQ >= ROM_BASE);
    idx   = regIdx_e'(addrQ[REG_IDX_W-1:0]);
  end

  assign ramCeN = ~inRam;
  assign regCeN = ~inReg;
  assign romCeN = ~inRom;

  always_comb begin
    strb.wrCfg = inReg && !wrN && !ale && (idx == REG_CFG);
    strb.wrSer = inReg && !wrN && !ale && (idx == REG_SER);
    strb.rdEn  = inReg && !rdN;
    strb.rdSel = idx;
  end

  // R1: held address only moves on an edge with ale high
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ale |=> $stable(addrQ));

  // R8: a write strobe can only come from a window access
  p_wr_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCfg || strb.wrSer) |-> (!regCeN && !wrN));
endmodule

// File: rtl/mbd_regfile.sv
module mbd_regfile
  import mbd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cntCap,
  input  logic [DATA_W-1:0] cntIn,
  input  logic [DATA_W-1:0] statIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe,
  output logic [DATA_W-1:0] cfgOut
);
  logic [DATA_W-1:0] cfgQ, serQ, cntQ, statQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ  <= '0;
      serQ  <= '0;
      cntQ  <= '0;
      statQ <= '0;
    end else begin
      if (strb.wrCfg) cfgQ <= wrData;
      if (strb.wrSer) serQ <= wrData;
      if (cntCap)     cntQ <= cntIn;
      statQ <= statIn;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      REG_CFG:  rdData = cfgQ;
      REG_CNT:  rdData = cntQ;
      REG_SER:  rdData = serQ;
      REG_STAT: rdData = statQ;
      default:  rdData = '0;
    endcase
  end

  assign rdOe   = strb.rdEn;
  assign cfgOut = cfgQ;

  // R9: the counter register changes only through its capture strobe
  p_cnt_ro_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cntCap |=> $stable(cntQ));

  // R8: configuration holds unless a configuration write occurs
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCfg |=> $stable(cfgQ));
endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder
  import mbd_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                BANK_W   = 2,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h1FF8,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ale,
  input  logic [ADDR_W-1:0] adIn,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              cntCap,
  input  logic [DATA_W-1:0] cntIn,
  input  logic [DATA_W-1:0] statIn,
  output logic              ramCeN,
  output logic              regCeN,
  output logic              romCeN,
  output logic [BANK_W-1:0] romBank,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe,
  output logic [DATA_W-1:0] cfgOut
);
  ctlStrobe_t strb;

  mbd_ctrl #(
    .ADDR_W  (ADDR_W),
    .REG_BASE(REG_BASE),
    .ROM_BASE(ROM_BASE)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ale   (ale),
    .adIn  (adIn),
    .rdN   (rdN),
    .wrN   (wrN),
    .ramCeN(ramCeN),
    .regCeN(regCeN),
    .romCeN(romCeN),
    .strb  (strb)
  );

  mbd_regfile #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(adIn[DATA_W-1:0]),
    .cntCap(cntCap),
    .cntIn (cntIn),
    .statIn(statIn),
    .rdData(rdData),
    .rdOe  (rdOe),
    .cfgOut(cfgOut)
  );

  // Bank bits go to the ROM unchanged
  assign romBank = bankSel;

  // R3 R4 R5: never more than one enable low at a time
  p_one_ce_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~ramCeN, ~regCeN, ~romCeN}) <= 1);

  // R7: the bus is driven only during a window read
  p_oe_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdOe |-> (!regCeN && !rdN));

  // R2: the cycle after a reset edge shows the idle state
  p_reset_idle_r2: assert property (@(posedge clk)
    !rstN |=> ({ramCeN, regCeN, romCeN} == 3'b111 && !rdOe && cfgOut == '0));
endmodule

// File: tb/mux_bus_decoder_bench.sv
module mux_bus_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ale = 1'b0;
  logic [15:0] adIn = 16'h0;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic [1:0]  bankSel = 2'd0;
  logic        cntCap = 1'b0;
  logic [7:0]  cntIn = 8'h0;
  logic [7:0]  statIn = 8'h0;
  logic        ramCeN, regCeN, romCeN, rdOe;
  logic [1:0]  romBank;
  logic [7:0]  rdData, cfgOut;

  always #5 clk = ~clk;

  mux_bus_decoder u_mux_bus_decoder (
    .clk(clk), .rstN(rstN), .ale(ale), .adIn(adIn), .rdN(rdN), .wrN(wrN),
    .bankSel(bankSel), .cntCap(cntCap), .cntIn(cntIn), .statIn(statIn),
    .ramCeN(ramCeN), .regCeN(regCeN), .romCeN(romCeN), .romBank(romBank),
    .rdData(rdData), .rdOe(rdOe), .cfgOut(cfgOut)
  );

  typedef struct {
    int    kind;   // 0 enables, 1 bank, 2 oe, 3 read data, 4 cfg
    int    exp;
    string req;
  } item_t;

  item_t sbq[$];
  int    nVec = 0;
  int    nBad = 0;
  bit    done = 1'b0;

  // Reference state
  logic [15:0] mAddr = 16'h0;
  bit          mValid = 1'b0;
  logic [7:0]  mCfg = 8'h0, mSer = 8'h0, mCnt = 8'h0, mStat = 8'h0;

  function automatic bit inWin(logic [15:0] a);
    return (a >= 16'h1FF8) && (a <= 16'h1FFF);
  endfunction

  function automatic int expCe(bit v, logic [15:0] a);
    if (!v) return 3'b111;
    if (a <= 16'h1FF7) return 3'b011;
    if (a <= 16'h1FFF) return 3'b101;
    return 3'b110;
  endfunction

  // Driver: update reference for the coming edge, queue expectations
  task automatic step(string req);
    if (!rstN) begin
      mAddr = 16'h0; mValid = 1'b0;
      mCfg = 8'h0; mSer = 8'h0; mCnt = 8'h0; mStat = 8'h0;
    end else begin
      if (!wrN && !ale && mValid && inWin(mAddr)) begin
        if (mAddr[1:0] == 2'd0) mCfg = adIn[7:0];
        if (mAddr[1:0] == 2'd2) mSer = adIn[7:0];
      end
      if (cntCap) mCnt = cntIn;
      mStat = statIn;
      if (ale) begin mAddr = adIn; mValid = 1'b1; end
    end
    sbq.push_back('{0, expCe(mValid, mAddr), req});
    sbq.push_back('{1, int'(bankSel), "R6"});
    sbq.push_back('{2, int'(!rdN && mValid && inWin(mAddr)), req});
    if (!rdN && mValid && inWin(mAddr)) begin
      case (mAddr[1:0])
        2'd0: sbq.push_back('{3, int'(mCfg), req});
        2'd1: sbq.push_back('{3, int'(mCnt), req});
        2'd2: sbq.push_back('{3, int'(mSer), req});
        default: sbq.push_back('{3, int'(mStat), req});
      endcase
    end
    sbq.push_back('{4, int'(mCfg), req});
    @(negedge clk);
  endtask

  // Monitor: compare after the edge has settled
  always @(posedge clk) begin
    #2;
    while (sbq.size() > 0) begin
      item_t it;
      int act;
      it = sbq.pop_front();
      case (it.kind)
        0: act = int'({ramCeN, regCeN, romCeN});
        1: act = int'(romBank);
        2: act = int'(rdOe);
        3: act = int'(rdData);
        default: act = int'(cfgOut);
      endcase
      nVec++;
      if (act !== it.exp) begin
        nBad++;
        $display("FAIL %s kind %0d actual %0h expected %0h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic capture(logic [15:0] a, string req);
    ale = 1'b1; adIn = a; rdN = 1'b1; wrN = 1'b1;
    step(req);
    ale = 1'b0;
  endtask

  // Boundary address: capture, then hold with foreign bus contents (R1)
  task automatic probe(logic [15:0] a, logic [15:0] noise, string req);
    capture(a, req);
    adIn = noise;
    step("R1");
  endtask

  task automatic regWrite(logic [15:0] a, logic [7:0] d, string req);
    capture(a, req);
    adIn = {8'h00, d}; wrN = 1'b0;
    step(req);
    wrN = 1'b1;
  endtask

  task automatic regRead(logic [15:0] a, string req);
    capture(a, req);
    rdN = 1'b0;
    step(req);
    rdN = 1'b1;
    step(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R2: reset state, even with strobes active
    rdN = 1'b0; wrN = 1'b0;
    step("R2"); step("R2"); step("R2");
    rdN = 1'b1; wrN = 1'b1;
    rstN = 1'b1;
    step("R2");
    step("R2");

    // R3 R4 R5 with R1 hold cycles
    probe(16'h0000, 16'hFFFF, "R3");
    probe(16'h1FF7, 16'h2000, "R3");
    probe(16'h1FF8, 16'h0000, "R4");
    probe(16'h1FFF, 16'h4000, "R4");
    probe(16'h2000, 16'h1FF8, "R5");
    probe(16'hFFFF, 16'h1FF7, "R5");
    probe(16'h8000, 16'h1FFC, "R5");

    // R6: bank pass-through over every value
    for (int b = 0; b < 4; b++) begin
      bankSel = 2'(b);
      step("R6");
    end

    // R9: capture a count and a status
    cntIn = 8'h42; cntCap = 1'b1; statIn = 8'h81;
    step("R9");
    cntCap = 1'b0; cntIn = 8'h99;

    // R8 R7: writes then reads, including alias
    regWrite(16'h1FF8, 8'hA5, "R8");
    regWrite(16'h1FFA, 8'h3C, "R8");
    regRead(16'h1FF8, "R7");
    regRead(16'h1FFA, "R7");
    regRead(16'h1FFE, "R7");
    regWrite(16'h1FFC, 8'h5A, "R8");
    regRead(16'h1FF8, "R7");

    // R9: read-only slots ignore writes
    regWrite(16'h1FF9, 8'hFF, "R9");
    regWrite(16'h1FFB, 8'h00, "R9");
    regRead(16'h1FF9, "R9");
    regRead(16'h1FFF, "R9");
    regRead(16'h1FFD, "R9");

    // R8: write outside the window changes nothing
    regWrite(16'h1000, 8'h11, "R8");
    regWrite(16'h3000, 8'h22, "R8");
    regRead(16'h1FF8, "R8");

    // R7: read strobe outside the window leaves bus undriven
    regRead(16'h1FF7, "R7");
    regRead(16'h2000, "R7");

    step("R1");
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule